// File: doc/BRIEF.md
# S1 Synchronization Status Validator

This block follows the synchronization status byte carried once per received frame. Each frame strobe delivers the byte. Depending on a mode input, the block compares either the whole byte or only its upper nibble. A value is accepted only after it has arrived unchanged for a programmable number of consecutive frames. The accepted value is held on an output. Any change to it raises a delta bit, and that bit can raise an interrupt unless the interrupt is masked.

A second counter tracks how many consecutive frames have passed without a validating frame. When that count reaches its own programmed threshold, the block raises a failure flag. Loss of frame alignment restarts the persistence count. Frames that arrive while alignment is lost are discarded. Interpreting the quality-level codes is left to the logic downstream.

Top module: `s1_sync_validator`

## Requirements
- R1: After synchronous reset, `accepted` is 0 and `fail_flag`, `delta` and `irq` are 0.
- R2: In byte mode (`nibble_mode`=0) the full byte is compared. A frame validates when its value has been seen on N consecutive taken frames, N = `persist_thr`, with 0 treated as 1. Every further matching frame also validates. A new value appears on `accepted` in the cycle after the validating strobe.
- R3: In nibble mode (`nibble_mode`=1) only bits [7:4] are compared, and the value stored is {bits[7:4], 4'b0000}. Differences in bits [3:0] are ignored.
- R4: A taken frame whose compared value differs from the current candidate makes it the new candidate, with a match count of one.
- R5: A low-to-high transition of `oof` clears the match count. Strobes in cycles with `oof`=1 are not taken and change no state.
- R6: `fail_flag` sets after F consecutive taken frames that do not validate, F = `fail_thr` (0 treated as 1). Every validating frame clears this frame count, including one that repeats the accepted value.
- R7: `fail_flag` clears on the next validating frame.
- R8: `delta` sets when `accepted` changes. A `delta_clr` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq` equals `delta` AND NOT `irq_mask`.
- R10: Cycles without a taken strobe leave `accepted`, the match count and the failure count unchanged, whatever `s1_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| s1_byte | input | 8 | Received status byte, valid with the strobe |
| oof | input | 1 | Frame alignment lost |
| nibble_mode | input | 1 | 1: compare upper nibble only |
| persist_thr | input | 4 | Consecutive frames needed to validate |
| fail_thr | input | 4 | Non-validating frames before failure |
| delta_clr | input | 1 | Clears the delta bit |
| irq_mask | input | 1 | Masks the interrupt |
| accepted | output | 8 | Last validated value |
| fail_flag | output | 1 | No validated message within the window |
| delta | output | 1 | Accepted value changed |
| irq | output | 1 | Unmasked delta |

## Verification
The case hardest to reach is an alignment loss that arrives partway through a persistence run. The match count is never visible at the ports, so the bench makes it observable: it sends fewer matching frames than the threshold, pulses `oof` with strobes inside the window, and then sends the same value again. It checks that acceptance needs a full new run. The failure window is driven the same way. Alternating values starve validation until the flag rises, and a single repeat of the already accepted value must then drop the flag without setting `delta`. A long pseudo-random frame stream covers the remaining interleavings against the reference model.

// File: rtl/s1v_pkg.sv
package s1v_pkg;
  localparam int S1V_DATA_W = 8;
  localparam int S1V_KEEP_W = 4;
  localparam int S1V_THR_W  = 4;
endpackage

// File: rtl/s1v_field_sel.sv
module s1v_field_sel #(
  parameter int DATA_W = s1v_pkg::S1V_DATA_W,
  parameter int KEEP_W = s1v_pkg::S1V_KEEP_W
) (
  input  logic              nibble_mode,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] field
);
  localparam int LOW_TOP = DATA_W - KEEP_W;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i >= LOW_TOP) begin : g_keep
      assign field[i] = raw[i];
    end else begin : g_drop
      assign field[i] = raw[i] & ~nibble_mode;
    end
  end
endmodule

// File: rtl/s1v_persist.sv
module s1v_persist #(
  parameter int DATA_W = s1v_pkg::S1V_DATA_W,
  parameter int THR_W  = s1v_pkg::S1V_THR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              oof,
  input  logic [DATA_W-1:0] field,
  input  logic [THR_W-1:0]  thr,
  output logic              valid_now
);
  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};
  localparam logic [THR_W-1:0] ONE     = {{(THR_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] cand_q;
  logic [THR_W-1:0]  cnt_q, cnt_nxt, thr_eff;
  logic              oof_q, oof_rise, same;

  assign oof_rise = oof & ~oof_q;
  assign same     = (field == cand_q);
  assign thr_eff  = (thr == '0) ? ONE : thr;

  always_comb begin
    if (!same)               cnt_nxt = ONE;
    else if (cnt_q == CNT_MAX) cnt_nxt = CNT_MAX;
    else                     cnt_nxt = cnt_q + ONE;
  end

  assign valid_now = take & (cnt_nxt >= thr_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      cnt_q  <= '0;
      oof_q  <= 1'b0;
    end else begin
      oof_q <= oof;
      if (oof_rise) begin
        cnt_q <= '0;
      end else if (take) begin
        cand_q <= field;
        cnt_q  <= cnt_nxt;
      end
    end
  end

  AST_OOF_CLEARS_CNT: assert property (@(posedge clk) disable iff (rst)
    $rose(oof) |=> (cnt_q == '0)); // R5

  AST_RESTART_AT_ONE: assert property (@(posedge clk) disable iff (rst)
    (take && !same) |=> (cnt_q == ONE)); // R4
endmodule

// File: rtl/s1v_fail_timer.sv
module s1v_fail_timer #(
  parameter int THR_W = s1v_pkg::S1V_THR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             valid_now,
  input  logic [THR_W-1:0] thr,
  output logic             fail_flag
);
  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};
  localparam logic [THR_W-1:0] ONE     = {{(THR_W-1){1'b0}}, 1'b1};

  logic [THR_W-1:0] fcnt_q, fcnt_nxt, thr_eff;

  assign thr_eff  = (thr == '0) ? ONE : thr;
  assign fcnt_nxt = (fcnt_q == CNT_MAX) ? CNT_MAX : fcnt_q + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q    <= '0;
      fail_flag <= 1'b0;
    end else if (take) begin
      if (valid_now) begin
        fcnt_q    <= '0;
        fail_flag <= 1'b0;
      end else begin
        fcnt_q <= fcnt_nxt;
        if (fcnt_nxt >= thr_eff) fail_flag <= 1'b1;
      end
    end
  end

  AST_VALID_CLEARS_FAIL: assert property (@(posedge clk) disable iff (rst)
    (take && valid_now) |=> !fail_flag); // R7

  AST_FAIL_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_flag) |-> $past(take && !valid_now)); // R6
endmodule

// File: rtl/s1_sync_validator.sv
module s1_sync_validator #(
  parameter int DATA_W = s1v_pkg::S1V_DATA_W,
  parameter int KEEP_W = s1v_pkg::S1V_KEEP_W,
  parameter int THR_W  = s1v_pkg::S1V_THR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] s1_byte,
  input  logic              oof,
  input  logic              nibble_mode,
  input  logic [THR_W-1:0]  persist_thr,
  input  logic [THR_W-1:0]  fail_thr,
  input  logic              delta_clr,
  input  logic              irq_mask,
  output logic [DATA_W-1:0] accepted,
  output logic              fail_flag,
  output logic              delta,
  output logic              irq
);
  localparam int LOW_W = DATA_W - KEEP_W;

  logic [DATA_W-1:0] field;
  logic              take, valid_now, changes;

  assign take = frame_stb & ~oof;

  s1v_field_sel #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_sel (
    .nibble_mode(nibble_mode), .raw(s1_byte), .field(field)
  );

  s1v_persist #(.DATA_W(DATA_W), .THR_W(THR_W)) u_persist (
    .clk(clk), .rst(rst), .take(take), .oof(oof), .field(field),
    .thr(persist_thr), .valid_now(valid_now)
  );

  s1v_fail_timer #(.THR_W(THR_W)) u_fail (
    .clk(clk), .rst(rst), .take(take), .valid_now(valid_now),
    .thr(fail_thr), .fail_flag(fail_flag)
  );

  assign changes = valid_now & (field != accepted);

  always_ff @(posedge clk) begin
    if (rst) begin
      accepted <= '0;
      delta    <= 1'b0;
    end else begin
      if (changes) accepted <= field;
      if (changes)        delta <= 1'b1;
      else if (delta_clr) delta <= 1'b0;
    end
  end

  assign irq = delta & ~irq_mask;

  AST_DELTA_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (accepted != $past(accepted)) |-> delta); // R8

  AST_CHANGE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    (accepted != $past(accepted)) |-> $past(frame_stb && !oof)); // R10

  AST_NIBBLE_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((accepted != $past(accepted)) && $past(nibble_mode)) |-> (accepted[LOW_W-1:0] == '0)); // R3
endmodule

// File: tb/tb_s1_sync_validator.sv
module tb_s1_sync_validator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic [7:0] s1_byte = 8'h00;
  logic       oof = 1'b0;
  logic       nibble_mode = 1'b0;
  logic [3:0] persist_thr = 4'd3;
  logic [3:0] fail_thr = 4'd8;
  logic       delta_clr = 1'b0;
  logic       irq_mask = 1'b0;
  logic [7:0] accepted;
  logic       fail_flag, delta, irq;

  int checks = 0;
  int errors = 0;
  string cur = "R1";

  // reference model state
  int m_acc = 0, m_cand = 0, m_cnt = 0, m_fcnt = 0;
  bit m_fail = 0, m_delta = 0, m_oofq = 0;

  always #5 clk = ~clk;

  s1_sync_validator dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .s1_byte(s1_byte), .oof(oof),
    .nibble_mode(nibble_mode), .persist_thr(persist_thr), .fail_thr(fail_thr),
    .delta_clr(delta_clr), .irq_mask(irq_mask), .accepted(accepted),
    .fail_flag(fail_flag), .delta(delta), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_cand = 0; m_cnt = 0; m_fcnt = 0;
      m_fail = 0; m_delta = 0; m_oofq = 0;
    end else begin
      bit dset;
      dset = 0;
      if (oof && !m_oofq) m_cnt = 0;
      if (frame_stb && !oof) begin
        int f, n, fl;
        f  = nibble_mode ? (int'(s1_byte) & 'hF0) : int'(s1_byte);
        n  = (persist_thr == 0) ? 1 : int'(persist_thr);
        fl = (fail_thr == 0) ? 1 : int'(fail_thr);
        if (f == m_cand) m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
        else begin m_cand = f; m_cnt = 1; end
        if (m_cnt >= n) begin
          if (f != m_acc) begin m_acc = f; dset = 1; end
          m_fcnt = 0; m_fail = 0;
        end else begin
          m_fcnt = (m_fcnt < 15) ? m_fcnt + 1 : 15;
          if (m_fcnt >= fl) m_fail = 1;
        end
      end
      if (dset) m_delta = 1;
      else if (delta_clr) m_delta = 0;
      m_oofq = oof;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("accepted", int'(accepted), m_acc);
    chk("fail_flag", int'(fail_flag), int'(m_fail));
    chk("delta", int'(delta), int'(m_delta));
    chk("irq", int'(irq), int'(m_delta && !irq_mask)); // R9
  endtask

  task automatic frame(logic [7:0] v);
    frame_stb = 1'b1; s1_byte = v; cyc();
    frame_stb = 1'b0; s1_byte = ~v; cyc();
  endtask

  task automatic clr_delta();
    delta_clr = 1'b1; cyc(); delta_clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lfsr;
    repeat (3) cyc();
    cur = "R1";
    chk("reset accepted", int'(accepted), 0);
    chk("reset fail", int'(fail_flag), 0);
    chk("reset irq", int'(irq), 0);
    rst = 1'b0; cyc();

    cur = "R2"; persist_thr = 4'd3;
    frame(8'hA5); frame(8'hA5);
    chk("not yet", int'(accepted), 0);
    frame(8'hA5);
    chk("accepted A5", int'(accepted), 'hA5);
    frame(8'hA5);
    cur = "R8"; clr_delta();
    chk("delta cleared", int'(delta), 0);

    cur = "R4";
    frame(8'h3C); frame(8'h3C); frame(8'h5A); frame(8'h3C); frame(8'h3C);
    chk("restart held", int'(accepted), 'hA5);
    frame(8'h3C);
    chk("accepted 3C", int'(accepted), 'h3C);

    cur = "R3"; nibble_mode = 1'b1; persist_thr = 4'd2;
    frame(8'h71); frame(8'h7E);
    chk("nibble stored", int'(accepted), 'h70);
    frame(8'h79);
    nibble_mode = 1'b0;

    cur = "R5"; persist_thr = 4'd3;
    frame(8'h22); frame(8'h22);
    oof = 1'b1; cyc(); frame(8'h22); frame(8'h22);
    oof = 1'b0; cyc();
    frame(8'h22); frame(8'h22);
    chk("oof restarted", int'(accepted), 'h70);
    frame(8'h22);
    chk("accepted 22", int'(accepted), 'h22);

    cur = "R10";
    for (int i = 0; i < 6; i++) begin s1_byte = 8'(i * 37); cyc(); end
    chk("no strobe no change", int'(accepted), 'h22);

    cur = "R6"; fail_thr = 4'd4; persist_thr = 4'd2;
    frame(8'h11); frame(8'h12); frame(8'h11);
    chk("fail pending", int'(fail_flag), 0);
    frame(8'h12);
    chk("fail set", int'(fail_flag), 1);
    cur = "R7"; clr_delta();
    frame(8'h22); frame(8'h22);
    chk("fail cleared by same value", int'(fail_flag), 0);
    chk("no delta on same value", int'(delta), 0);

    cur = "R2"; persist_thr = 4'd0; fail_thr = 4'd0;
    frame(8'h44);
    chk("thr zero acts as one", int'(accepted), 'h44);

    cur = "R8"; persist_thr = 4'd1;
    frame_stb = 1'b1; s1_byte = 8'h55; delta_clr = 1'b1; cyc();
    frame_stb = 1'b0; delta_clr = 1'b0;
    chk("set beats clear", int'(delta), 1);
    cur = "R9"; irq_mask = 1'b1; cyc();
    chk("irq masked", int'(irq), 0);
    irq_mask = 1'b0; cyc();
    chk("irq unmasked", int'(irq), 1);

    cur = "R6"; lfsr = 'h5A;
    for (int i = 0; i < 3000; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 'hFF;
      persist_thr = 4'(lfsr % 5);
      fail_thr    = 4'((lfsr >> 2) % 7);
      nibble_mode = (i / 500) % 2 == 1;
      oof         = (lfsr & 'h1F) == 3;
      delta_clr   = (lfsr & 'h0F) == 9;
      irq_mask    = lfsr[6];
      frame_stb   = lfsr[0] | lfsr[1];
      s1_byte     = 8'({lfsr[7:6], 2'b00, lfsr[3:2], lfsr[5], 1'b0});
      cyc();
    end
    frame_stb = 1'b0; oof = 1'b0; delta_clr = 1'b0;
    cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule